// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Source with Power-of-Two Divider

This block is a numerically controlled frequency source. A wide phase register adds a programmable tuning word on every clock and wraps modulo its width. The top bit of that register is a square wave whose frequency is the tuning word times the clock frequency, divided by two to the register width. Because a period seldom spans a whole number of clocks, the high and low phases of this wave differ by one clock from one phase to the next.

A second binary counter advances once per synthesized cycle, on a one-clock enable pulse produced at each rising edge of the square wave. A tap multiplexer picks one counter bit, chosen by a 5-bit select, as the divided output. Selecting bit D divides the square-wave frequency by 2^(D+1). Everything runs in the single system clock domain. The tuning word is normally chosen so that the raw wave lies between one sixteenth and one thirty-second of the clock rate.

Top module: `nco_divider_top`

## Requirements
- R1: On every clock edge outside reset, the 32-bit phase register takes its previous value plus the tuning word, modulo 2^32, and `wave_o` equals bit 31 of the phase register.
- R2: While `srst_i` is high at a clock edge, the phase register, the edge-detect register and the divider counter are cleared, so `wave_o` and `div_o` are both 0 after that edge.
- R3: With tuning word 204010946, every complete high phase and every complete low phase of `wave_o` lasts 10 or 11 clocks.
- R4: The divider counter rises by exactly one at the clock edge following each cycle in which `wave_o` is 1 and was 0 in the cycle before, and holds otherwise.
- R5: `div_o` equals bit `tap_sel_i` (0 to 31) of the divider counter, so its frequency is that of `wave_o` divided by 2^(tap_sel_i+1); a select of 4 divides by 32.
- R6: A change of `tap_sel_i` reaches `div_o` in the same cycle, with no clock edge in between.
- R7: A new tuning word is used from the next addition on; the phase register is not cleared, so phase continues from its current value.
- R8: With a tuning word of 0, `wave_o` and `div_o` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| srst_i | input | 1 | Synchronous reset, active high |
| tune_word_i | input | 32 | Phase increment added each clock |
| tap_sel_i | input | 5 | Divider counter bit routed to `div_o` |
| wave_o | output | 1 | Raw square wave, top bit of the phase register |
| div_o | output | 1 | Divided square wave |

## Verification
The tuning word, reset and select are applied between clock edges; `wave_o` answers one clock edge later, while the counter, and thus `div_o`, lags the rising edge of `wave_o` by one more edge. The scoreboard model steps these three registers in the same order, so each expected pair is queued at the driving edge and compared a quarter period after the next rising edge. A select change is compared a nanosecond after it is driven, before any edge, since it acts combinationally; phase lengths are counted on the sampled wave.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int unsigned PHASE_W_DEF = 32;
    localparam int unsigned DIV_W_DEF   = 32;

    // Rising-edge condition shared by the edge detector and its checks.
    function automatic logic rise_of(input logic now_v, input logic before_v);
        return now_v & ~before_v;
    endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int unsigned PHASE_W = nco_pkg::PHASE_W_DEF
) (
    input  logic               clk_i,
    input  logic               srst_i,
    input  logic [PHASE_W-1:0] step_i,
    output logic               wave_o
);
    localparam int unsigned TOP_BIT = PHASE_W - 1;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc + step_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign wave_o = st_q.acc[TOP_BIT];

    assert_wrap_add_R1 : assert property (@(posedge clk_i) disable iff (srst_i)
        !$past(srst_i) |-> st_q.acc == $past(st_q.acc) + $past(step_i));

    assert_zero_step_hold_R8 : assert property (@(posedge clk_i) disable iff (srst_i)
        (!$past(srst_i) && $past(step_i) == '0) |-> $stable(wave_o));

endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk_i,
    input  logic srst_i,
    input  logic level_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i) begin
            st_d.prev = 1'b0;
        end else begin
            st_d.prev = level_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pulse_o = nco_pkg::rise_of(level_i, st_q.prev);

    // A pulse never lasts more than one clock (R4).
    assert_single_pulse_R4 : assert property (@(posedge clk_i) disable iff (srst_i)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/bin_counter.sv
module bin_counter #(
    parameter int unsigned CNT_W = nco_pkg::DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i) begin
            st_d.cnt = '0;
        end else if (en_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    assert_count_step_R4 : assert property (@(posedge clk_i) disable iff (srst_i)
        en_i |=> count_o == $past(count_o) + 1'b1);

    assert_count_hold_R4 : assert property (@(posedge clk_i) disable iff (srst_i)
        !en_i |=> $stable(count_o));

endmodule

// File: rtl/tap_mux.sv
module tap_mux #(
    parameter int unsigned CNT_W = nco_pkg::DIV_W_DEF,
    localparam int unsigned SEL_W = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tap_o
);
    always_comb begin
        tap_o = 1'b0;
        for (int unsigned i = 0; i < CNT_W; i++) begin
            if (sel_i == SEL_W'(i)) begin
                tap_o = count_i[i];
            end
        end
    end
endmodule

// File: rtl/nco_divider_top.sv
module nco_divider_top #(
    parameter int unsigned PHASE_W = nco_pkg::PHASE_W_DEF,
    parameter int unsigned DIV_W   = nco_pkg::DIV_W_DEF,
    localparam int unsigned SEL_W  = (DIV_W > 1) ? $clog2(DIV_W) : 1
) (
    input  logic               clk_i,
    input  logic               srst_i,
    input  logic [PHASE_W-1:0] tune_word_i,
    input  logic [SEL_W-1:0]   tap_sel_i,
    output logic               wave_o,
    output logic               div_o
);
    logic             wave;
    logic             rise_pulse;
    logic [DIV_W-1:0] div_count;

    phase_accum #(.PHASE_W(PHASE_W)) u_accum (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .step_i (tune_word_i),
        .wave_o (wave)
    );

    rise_detect u_rise (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .level_i (wave),
        .pulse_o (rise_pulse)
    );

    bin_counter #(.CNT_W(DIV_W)) u_count (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .en_i    (rise_pulse),
        .count_o (div_count)
    );

    tap_mux #(.CNT_W(DIV_W)) u_tap (
        .count_i (div_count),
        .sel_i   (tap_sel_i),
        .tap_o   (div_o)
    );

    assign wave_o = wave;

    assert_reset_clear_R2 : assert property (@(posedge clk_i) disable iff (srst_i)
        $past(srst_i) |-> (!wave_o && !div_o));

    // With bit 0 selected, the output toggles exactly after each rising edge (R5).
    assert_tap0_toggle_R5 : assert property (@(posedge clk_i) disable iff (srst_i)
        (tap_sel_i == '0 && $past(tap_sel_i) == '0 && !$past(srst_i))
            |-> ((div_o != $past(div_o)) == $past(rise_pulse)));

endmodule

// File: tb/sim_nco_divider_top.sv
module sim_nco_divider_top;

    localparam time HALF = 10ns;

    typedef struct {
        logic  wave;
        logic  div;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic [31:0] tune = '0;
    logic [4:0]  tap = '0;
    logic        wave, div;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    exp_t sb[$];

    // reference state
    logic [31:0] acc_m = '0;
    logic        prev_m = 1'b0;
    logic [31:0] cnt_m = '0;
    logic [4:0]  last_tap = '0;

    // phase-length monitor control
    bit run_chk = 1'b0;

    always #HALF clk = ~clk;

    nco_divider_top u0 (
        .clk_i       (clk),
        .srst_i      (srst),
        .tune_word_i (tune),
        .tap_sel_i   (tap),
        .wave_o      (wave),
        .div_o       (div)
    );

    task automatic drive(input logic rst, input logic [31:0] n, input logic [4:0] d,
                         input string tag);
        logic rise;
        exp_t e;
        @(negedge clk);
        srst = rst;
        tune = n;
        tap  = d;
        if (!rst && d != last_tap) begin
            #1;
            n_vec++;
            if (div !== cnt_m[d]) begin
                n_bad++;
                $display("FAIL R6 select change: div_o=%b expected %b (sel %0d)", div, cnt_m[d], d);
            end
        end
        last_tap = d;
        if (rst) begin
            acc_m = '0; prev_m = 1'b0; cnt_m = '0;
        end else begin
            rise   = acc_m[31] & ~prev_m;
            cnt_m  = cnt_m + {31'b0, rise};
            prev_m = acc_m[31];
            acc_m  = acc_m + n;
        end
        e.wave = acc_m[31];
        e.div  = cnt_m[d];
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic run(input int cycles, input logic [31:0] n, input logic [4:0] d,
                       input string tag);
        for (int i = 0; i < cycles; i++) drive(1'b0, n, d, tag);
    endtask

    // monitor: compares a quarter period after each rising edge
    int  runlen = 0;
    bit  seen_edge = 1'b0;
    logic last_wave = 1'b0;
    always @(posedge clk) begin
        exp_t e;
        #(HALF/2);
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_vec++;
            if (wave !== e.wave || div !== e.div) begin
                n_bad++;
                $display("FAIL %s: wave_o/div_o=%b%b expected %b%b", e.tag, wave, div, e.wave, e.div);
            end
        end
        if (run_chk) begin
            if (wave !== last_wave) begin
                if (seen_edge) begin
                    n_vec++;
                    if (runlen != 10 && runlen != 11) begin
                        n_bad++;
                        $display("FAIL R3 phase length: %0d clocks expected 10 or 11", runlen);
                    end
                end
                seen_edge = 1'b1;
                runlen = 1;
            end else begin
                runlen++;
            end
        end else begin
            seen_edge = 1'b0;
            runlen = 0;
        end
        last_wave = wave;
    end

    initial begin
        // R2: reset state
        for (int i = 0; i < 3; i++) drive(1'b1, 32'h1000_0000, 5'd0, "R2 reset");
        // R1, R4, R5: 16-clock period, divide by 2
        run(120, 32'h1000_0000, 5'd0, "R1/R4/R5 sel0");
        // R6 then R5: divide by 8
        run(300, 32'h1000_0000, 5'd2, "R5 sel2");
        // R5: divide by 32
        run(1100, 32'h1000_0000, 5'd4, "R5 sel4");
        // R7: new word without clearing phase; R3 phase lengths
        run_chk = 1'b1;
        run(600, 32'd204010946, 5'd1, "R7 word change");
        run_chk = 1'b0;
        // R8: zero word holds both outputs
        run(80, 32'd0, 5'd1, "R8 zero word");
        // R1: near-full-scale word wraps
        run(100, 32'hF000_0001, 5'd0, "R1 wrap");
        // R2: reset in mid-run, then resume
        for (int i = 0; i < 4; i++) drive(1'b1, 32'hF000_0001, 5'd3, "R2 mid reset");
        run(200, 32'h0C00_0000, 5'd3, "R4/R5 resume");
        // R6: select changes on a live counter
        run(5, 32'h0C00_0000, 5'd0, "R6 sel0");
        run(5, 32'h0C00_0000, 5'd31, "R6 sel31");
        run(5, 32'h0C00_0000, 5'd1, "R6 sel1");
        @(posedge clk);
        #(HALF);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule